// File: doc/BRIEF.md
# Link Power Status Monitor

This block decides, from a single power-status line driven by the attached link-layer controller, whether that controller is powered. The line is brought into the system-clock domain through two flops. Its low time is then measured against two limits. A steady high line, or a pulsed line whose low stretches stay short, means "powered". A low stretch longer than the first limit puts the PHY-to-link interface into a low-power reset condition. A much longer stretch turns the interface fully off.

In the low-power reset condition, the interface control and data outputs are forced to zero and the incoming link request is blocked. The system clock toward the link keeps running. In the off condition, a registered clock-enable output also drops, so that clock logic outside the block can stop the system clock. Hardware reset and the power-down input both place the interface directly in the off condition. A single high sample ends either low-power condition. On recovery the clock enable comes back first, and the data path reopens one cycle later. A link-active flag combines the powered decision with a software control bit.

Top module: `link_power_monitor`

## Requirements
- R1: With the status line held low after being high, the state stays active (code 2'b00) until the (RESET_LIMIT+4)th rising clock edge after the fall. On that edge it becomes low-power reset (code 2'b01). Low stretches that stay at or below RESET_LIMIT synchronized samples never leave the active state.
- R2: In low-power reset, ctl_out and data_out read zero, lreq_out reads 0 whatever lreq_in is, and sysclk_en stays 1.
- R3: With the line still low, the state becomes disabled (code 2'b10) on the (DISABLE_LIMIT+4)th rising edge after the fall, and sysclk_en is 0 from that edge on.
- R4: While rst_n is low, the state is disabled, sysclk_en is 0 and every gated output reads zero.
- R5: pd_in high at a rising edge puts the block in the disabled state with sysclk_en 0 on that edge, the same as hardware reset.
- R6: link_active is 1 exactly when the state is active and lctrl_in is 1.
- R7: From low-power reset or disabled, a high line becomes the active state with sysclk_en 1 on the 3rd rising edge after the rise. The gated outputs start passing on the 4th edge.
- R8: In the active state with the path open, ctl_out, data_out and lreq_out equal ctl_in, data_in and lreq_in.
- R9: A low stretch of any length, however long, keeps the disabled state with sysclk_en 0; the low-time count saturates and never wraps back into a shorter-looking stretch.
- R10: state_code uses 2'b00 for active, 2'b01 for low-power reset and 2'b10 for disabled, and never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| pd_in | input | 1 | Power-down, acts as a synchronous reset |
| lps_in | input | 1 | Asynchronous link power-status line |
| lctrl_in | input | 1 | Software link-enable control bit |
| lreq_in | input | 1 | Link request from the link layer |
| ctl_in | input | CTL_W | Internal interface control value |
| data_in | input | DATA_W | Internal interface data value |
| ctl_out | output | CTL_W | Gated control toward the link |
| data_out | output | DATA_W | Gated data toward the link |
| lreq_out | output | 1 | Gated link request toward the arbiter |
| sysclk_en | output | 1 | Registered enable for the system clock output |
| link_active | output | 1 | Link considered powered and enabled |
| state_code | output | 2 | Interface state (active, reset, disabled) |

## Verification
The assertions assume that the status line reaches the block only through its synchronizer. They also assume that rst_n and pd_in are quiet at the clock edges they are sampled on, so they are stable when the checks are active. The stimulus changes every input only at the falling clock edge and holds pd_in for whole cycles. Its random low stretches cluster around both limits, so that each threshold is crossed and narrowly missed many times. Short high pulses in between exercise the recovery path from both low-power states.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LP_ACTIVE   = 2'b00,
        LP_RESET    = 2'b01,
        LP_DISABLED = 2'b10
    } lp_state_e;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_in;
        sy_d.s2 = sy_q.s1;
        if (clr) begin
            sy_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_out = sy_q.s2;

endmodule

// File: rtl/lpm_lowtimer.sv
module lpm_lowtimer #(
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample_hi,
    output logic past_reset,
    output logic past_disable
);

    localparam int SAT_VAL = DISABLE_LIMIT + 1;
    localparam int CW      = $clog2(SAT_VAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (sample_hi) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt != CW'(SAT_VAL)) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
        if (clr) begin
            tm_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign past_reset   = tm_q.cnt > CW'(RESET_LIMIT);
    assign past_disable = tm_q.cnt > CW'(DISABLE_LIMIT);

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n || clr)
        tm_q.cnt <= CW'(SAT_VAL)); // R9
    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || clr)
        sample_hi |=> !past_reset && !past_disable); // R1
    AST_ORDERED_LIMITS: assert property (@(posedge clk) disable iff (!rst_n || clr)
        past_disable |-> past_reset); // R3

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      sample_hi,
    input  logic      past_reset,
    input  logic      past_disable,
    output lp_state_e state,
    output logic      clk_en,
    output logic      gate_open
);

    typedef struct packed {
        lp_state_e st;
        logic      clk_en;
        logic      gate;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: LP_DISABLED, clk_en: 1'b0, gate: 1'b0};

    fsm_t fs_d, fs_q;
    lp_state_e nxt;

    always_comb begin
        nxt = fs_q.st;
        unique case (fs_q.st)
            LP_ACTIVE: begin
                if (past_reset && !sample_hi) begin
                    nxt = LP_RESET;
                end
            end
            LP_RESET: begin
                if (sample_hi) begin
                    nxt = LP_ACTIVE;
                end else if (past_disable) begin
                    nxt = LP_DISABLED;
                end
            end
            LP_DISABLED: begin
                if (sample_hi) begin
                    nxt = LP_ACTIVE;
                end
            end
            default: nxt = LP_DISABLED;
        endcase

        fs_d        = fs_q;
        fs_d.st     = nxt;
        fs_d.clk_en = (nxt != LP_DISABLED);
        fs_d.gate   = (nxt == LP_ACTIVE) && (fs_q.st == LP_ACTIVE);
        if (clr) begin
            fs_d = FSM_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= FSM_RST;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign state     = fs_q.st;
    assign clk_en    = fs_q.clk_en;
    assign gate_open = fs_q.gate;

    AST_DISABLED_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (fs_q.st == LP_DISABLED) |-> !fs_q.clk_en); // R3
    AST_RESET_ONLY_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(fs_q.st == LP_RESET) |-> $past(fs_q.st) == LP_ACTIVE); // R1
    AST_CLK_BEFORE_GATE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(fs_q.gate) |-> $past(fs_q.clk_en)); // R7
    AST_NO_SKIP_TO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (fs_q.st == LP_ACTIVE) |=> (fs_q.st != LP_DISABLED)); // R3

endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
    import lpm_pkg::*;
#(
    parameter int CTL_W         = 2,
    parameter int DATA_W        = 8,
    parameter int RESET_LIMIT   = 128,
    parameter int DISABLE_LIMIT = 1280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_in,
    input  logic              lps_in,
    input  logic              lctrl_in,
    input  logic              lreq_in,
    input  logic [CTL_W-1:0]  ctl_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [DATA_W-1:0] data_out,
    output logic              lreq_out,
    output logic              sysclk_en,
    output logic              link_active,
    output logic [1:0]        state_code
);

    logic      lps_s;
    logic      past_reset;
    logic      past_disable;
    lp_state_e st;
    logic      gate_open;

    lpm_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pd_in),
        .async_in (lps_in),
        .sync_out (lps_s)
    );

    lpm_lowtimer #(
        .RESET_LIMIT   (RESET_LIMIT),
        .DISABLE_LIMIT (DISABLE_LIMIT)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (pd_in),
        .sample_hi    (lps_s),
        .past_reset   (past_reset),
        .past_disable (past_disable)
    );

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (pd_in),
        .sample_hi    (lps_s),
        .past_reset   (past_reset),
        .past_disable (past_disable),
        .state        (st),
        .clk_en       (sysclk_en),
        .gate_open    (gate_open)
    );

    always_comb begin
        ctl_out     = gate_open ? ctl_in  : '0;
        data_out    = gate_open ? data_in : '0;
        lreq_out    = gate_open & lreq_in;
        link_active = (st == LP_ACTIVE) & lctrl_in;
        state_code  = st;
    end

    AST_CLOSED_PATH_ZERO: assert property (@(posedge clk) disable iff (!rst_n || pd_in)
        (state_code != LP_ACTIVE) |-> (ctl_out == '0 && data_out == '0 && !lreq_out)); // R2
    AST_RESET_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n || pd_in)
        (state_code == LP_RESET) |-> sysclk_en); // R2
    AST_LINK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n || pd_in)
        link_active |-> (state_code == LP_ACTIVE && lctrl_in)); // R6
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n || pd_in)
        state_code != 2'b11); // R10
    AST_PD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        pd_in |=> (state_code == LP_DISABLED && !sysclk_en)); // R5

endmodule

// File: tb/link_power_monitor_tb_top.sv
module link_power_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 2;
    localparam int DW         = 8;
    localparam int RL         = 128;
    localparam int DL         = 1280;
    localparam int SAT        = DL + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_in = 1'b0;
    logic          lps_in = 1'b1;
    logic          lctrl_in = 1'b0;
    logic          lreq_in = 1'b0;
    logic [CW-1:0] ctl_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] ctl_out;
    logic [DW-1:0] data_out;
    logic          lreq_out;
    logic          sysclk_en;
    logic          link_active;
    logic [1:0]    state_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit hold_side = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_power_monitor #(
        .CTL_W (CW), .DATA_W (DW), .RESET_LIMIT (RL), .DISABLE_LIMIT (DL)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pd_in (pd_in), .lps_in (lps_in),
        .lctrl_in (lctrl_in), .lreq_in (lreq_in), .ctl_in (ctl_in), .data_in (data_in),
        .ctl_out (ctl_out), .data_out (data_out), .lreq_out (lreq_out),
        .sysclk_en (sysclk_en), .link_active (link_active), .state_code (state_code)
    );

    // Reference model built from the requirements (codes: 0 active, 1 reset, 2 disabled).
    logic       m_s1, m_s2, m_clk_en, m_gate;
    logic [1:0] m_state;
    int         m_cnt;

    function automatic logic [1:0] next_state(logic [1:0] cur, logic hi, int cnt);
        case (cur)
            2'd0: return (cnt > RL && !hi) ? 2'd1 : 2'd0;
            2'd1: return hi ? 2'd0 : ((cnt > DL) ? 2'd2 : 2'd1);
            default: return hi ? 2'd0 : 2'd2;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || pd_in) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_cnt <= 0;
            m_state <= 2'd2; m_clk_en <= 1'b0; m_gate <= 1'b0;
        end else begin
            logic [1:0] nx;
            nx = next_state(m_state, m_s2, m_cnt);
            m_s1 <= lps_in;
            m_s2 <= m_s1;
            m_cnt <= m_s2 ? 0 : ((m_cnt == SAT) ? SAT : m_cnt + 1);
            m_state <= nx;
            m_clk_en <= (nx != 2'd2);
            m_gate <= (nx == 2'd0) && (m_state == 2'd0);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R10 state_code", 32'(state_code), 32'(m_state));
        chk("R3 sysclk_en", 32'(sysclk_en), 32'(m_clk_en));
        chk("R8 ctl_out", 32'(ctl_out), m_gate ? 32'(ctl_in) : 32'd0);
        chk("R8 data_out", 32'(data_out), m_gate ? 32'(data_in) : 32'd0);
        chk("R2 lreq_out", 32'(lreq_out), 32'(m_gate & lreq_in));
        chk("R6 link_active", 32'(link_active), 32'((m_state == 2'd0) & lctrl_in));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) cmp_model();
            if (!hold_side) begin
                lreq_in  = 1'($urandom);
                lctrl_in = 1'($urandom);
                ctl_in   = CW'($urandom);
                data_in  = DW'($urandom);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1394_5A5A));
        // R4: hardware reset state with all-ones inputs
        hold_side = 1'b1;
        ctl_in = '1; data_in = '1; lreq_in = 1'b1; lctrl_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 state under reset", 32'(state_code), 32'd2);
        chk("R4 clk_en under reset", 32'(sysclk_en), 32'd0);
        chk("R4 outputs under reset", 32'({ctl_out, data_out, lreq_out}), 32'd0);
        rst_n = 1'b1;
        // R7: recovery after reset takes 3 edges, path opens on the 4th
        step(2);
        chk("R7 still disabled", 32'(state_code), 32'd2);
        step(1);
        chk("R7 active on 3rd edge", 32'(state_code), 32'd0);
        chk("R7 clk_en on 3rd edge", 32'(sysclk_en), 32'd1);
        chk("R7 path still closed", 32'(lreq_out), 32'd0);
        step(1);
        chk("R8 ctl passes", 32'(ctl_out), 32'(ctl_in));
        chk("R8 data passes", 32'(data_out), 32'(data_in));
        chk("R8 lreq passes", 32'(lreq_out), 32'd1);
        chk("R6 link active", 32'(link_active), 32'd1);
        lctrl_in = 1'b0;
        step(1);
        chk("R6 lctrl clear", 32'(link_active), 32'd0);
        lctrl_in = 1'b1;
        step(4);
        // R1 / R3: threshold timing from a clean fall
        lps_in = 1'b0;
        step(RL + 3);
        chk("R1 active just before limit", 32'(state_code), 32'd0);
        step(1);
        chk("R1 reset at limit", 32'(state_code), 32'd1);
        chk("R2 clk runs in reset", 32'(sysclk_en), 32'd1);
        chk("R2 lreq blocked", 32'(lreq_out), 32'd0);
        chk("R2 ctl zero", 32'(ctl_out), 32'd0);
        chk("R6 inactive in reset", 32'(link_active), 32'd0);
        step(DL - RL - 1);
        chk("R3 reset just before limit", 32'(state_code), 32'd1);
        step(1);
        chk("R3 disabled at limit", 32'(state_code), 32'd2);
        chk("R3 clk off", 32'(sysclk_en), 32'd0);
        // R9: very long low stays disabled
        step(3000);
        chk("R9 long low disabled", 32'(state_code), 32'd2);
        chk("R9 long low clk off", 32'(sysclk_en), 32'd0);
        lps_in = 1'b1;
        step(3);
        chk("R7 recover from disabled", 32'(state_code), 32'd0);
        step(1);
        chk("R7 path reopened", 32'(data_out), 32'(data_in));
        // R1: pulsed line with short lows stays active
        for (int p = 0; p < 20; p++) begin
            lps_in = 1'b0; step(RL - 8);
            lps_in = 1'b1; step(1);
        end
        step(4);
        chk("R1 pulsed stays active", 32'(state_code), 32'd0);
        // R5: power-down acts as reset
        pd_in = 1'b1;
        step(1);
        chk("R5 pd disables", 32'(state_code), 32'd2);
        chk("R5 pd clk off", 32'(sysclk_en), 32'd0);
        pd_in = 1'b0;
        step(3);
        chk("R5 recover after pd", 32'(state_code), 32'd0);
        // Random phase around both limits
        hold_side = 1'b0;
        for (int s = 0; s < 60; s++) begin
            int sel, lo;
            sel = int'($urandom % 4);
            case (sel)
                0: lo = 1 + int'($urandom % RL);
                1: lo = RL - 3 + int'($urandom % 8);
                2: lo = DL - 3 + int'($urandom % 8);
                default: lo = 200 + int'($urandom % 600);
            endcase
            lps_in = 1'b0; step(lo);
            lps_in = 1'b1; step(1 + int'($urandom % 12));
            if ($urandom % 8 == 0) begin
                pd_in = 1'b1; step(1 + int'($urandom % 3)); pd_in = 1'b0;
            end
        end
        step(10);
        finish_run();
    end

endmodule